// File: doc/BRIEF.md
# Key-Locked Configuration Register Guard

This block is a small register file on a simple register bus. It holds a handful of configuration words and drives them straight out to the logic they control: one general system-control word and four clock-enable words. No guarded word can be changed by accident. Each one belongs to one of two protection domains, and each domain has its own lock register. Software writes a fixed 32-bit key to a domain's lock register to open that domain. Any other value written there shuts it again.

The system domain covers the system-control word. The clock domain covers the core clock-enable word and the three peripheral-bus clock-enable words. A write to a guarded word whose domain is shut is dropped without any error signal, and the bus access still completes. Reads are never blocked. Reading a lock register returns 1 when its domain is open and 0 when it is shut.

The bus has no handshake. A write is taken on the rising clock edge where `bus_wr_en` is high. Read data is a combinational function of `bus_addr`.

Top module: `keyed_cfg_guard`

## Requirements
- R1: After reset both domains are shut and their lock registers read 0. The guarded words read and drive these values: system control (0x000) = 0x00000401, core clock enables (0x010) = 0x00000FFC, AHB clock enables (0x014) = 0x0000007F, APB0 clock enables (0x018) = 0x00007FFF, APB1 clock enables (0x01C) = 0x000001FF.
- R2: Writing 0x51AC0FFE to a lock register (system lock at 0x050, clock lock at 0x058) opens that domain. The lock register then reads 0x00000001.
- R3: Writing any value other than 0x51AC0FFE to a lock register shuts that domain. The lock register then reads 0x00000000. This applies to both locks.
- R4: A write to a guarded word while its domain is shut leaves the stored value and its output unchanged.
- R5: Opening the system domain allows writes to the system-control word only. The clock-domain words still reject writes, and the clock lock still reads 0.
- R6: Opening the clock domain allows writes to all four clock-enable words only. The system-control word still rejects writes, and the system lock still reads 0.
- R7: Writes to a lock register are always accepted, whatever the state of its domain. Writing the key to an open domain leaves it open. A lock read carries the state in bit 0 only, with every upper bit 0.
- R8: Guarded words read back their stored value whether their domain is open or shut. An unmapped address reads 0, and a write to it changes no word, even with both domains open.
- R9: An accepted write appears on the word's output and in its readback from the clock edge that takes the write. Before that edge the old value is still shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr_en | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| sys_ctrl_o | output | 32 | System-control word |
| core_gate_o | output | 32 | Core and memory clock-enable word |
| ahb_gate_o | output | 32 | AHB peripheral clock-enable word |
| apb0_gate_o | output | 32 | APB0 peripheral clock-enable word |
| apb1_gate_o | output | 32 | APB1 peripheral clock-enable word |

## Verification
Some rules are checked by assertions on every cycle:
- A lock opens after a key write and shuts after any other write to it.
- A lock never changes state without a write to its own register.
- A guarded word holds its value through a write that arrives while its domain is shut.
- A guarded word takes the bus data after a write that arrives while its domain is open.
- Lock reads have zero upper bits.

Other behaviour only the bench's scenarios can show:
- That the two domains are independent of each other.
- The exact reset values.
- That unmapped addresses are inert.
- That a key written to an already-open domain keeps it open.
- That readback works while a domain is shut.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

  localparam int NUM_REGS = 5;
  localparam int NUM_DOMS = 2;
  localparam int DOM_SYS  = 0;
  localparam int DOM_CLK  = 1;

  localparam logic [31:0] UNLOCK_KEY = 32'h51AC_0FFE;

  // byte offset of each guarded word
  function automatic logic [31:0] reg_offset(input int idx);
    case (idx)
      0:       reg_offset = 32'h000;
      1:       reg_offset = 32'h010;
      2:       reg_offset = 32'h014;
      3:       reg_offset = 32'h018;
      default: reg_offset = 32'h01C;
    endcase
  endfunction

  function automatic logic [31:0] reg_reset(input int idx);
    case (idx)
      0:       reg_reset = 32'h0000_0401;
      1:       reg_reset = 32'h0000_0FFC;
      2:       reg_reset = 32'h0000_007F;
      3:       reg_reset = 32'h0000_7FFF;
      default: reg_reset = 32'h0000_01FF;
    endcase
  endfunction

  // which lock domain guards each word
  function automatic int reg_domain(input int idx);
    reg_domain = (idx == 0) ? DOM_SYS : DOM_CLK;
  endfunction

  function automatic logic [31:0] lock_offset(input int dom);
    lock_offset = (dom == DOM_SYS) ? 32'h050 : 32'h058;
  endfunction

endpackage

// File: rtl/scfg_lock.sv
module scfg_lock #(
  parameter int          DATA_W = 32,
  parameter logic [31:0] KEY    = 32'h51AC_0FFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              open_o
);

  logic key_match;
  assign key_match = (wdata == DATA_W'(KEY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     open_o <= 1'b0;
    else if (wr_en) open_o <= key_match;
  end

  // R2
  lock_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata == DATA_W'(KEY)) |=> open_o);

  // R3
  lock_shuts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata != DATA_W'(KEY)) |=> !open_o);

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(open_o));

endmodule

// File: rtl/scfg_reg.sv
module scfg_reg #(
  parameter int                DATA_W = 32,
  parameter logic [DATA_W-1:0] RESET  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic              unlocked,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  logic accept;
  assign accept = wr_hit && unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= RESET;
    else if (accept) q <= wdata;
  end

  // R4
  locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !unlocked) |=> $stable(q));

  // R9
  open_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && unlocked) |=> (q == $past(wdata)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(q));

endmodule

// File: rtl/scfg_rdmux.sv
module scfg_rdmux
  import scfg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]   regs_q,
  input  logic [NUM_DOMS-1:0]               dom_open,
  output logic [DATA_W-1:0]                 rdata
);

  always_comb begin
    rdata = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (addr == ADDR_W'(reg_offset(r))) rdata = regs_q[r];
    end
    for (int d = 0; d < NUM_DOMS; d++) begin
      if (addr == ADDR_W'(lock_offset(d))) rdata = DATA_W'(dom_open[d]);
    end
  end

endmodule

// File: rtl/keyed_cfg_guard.sv
module keyed_cfg_guard
  import scfg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] sys_ctrl_o,
  output logic [DATA_W-1:0] core_gate_o,
  output logic [DATA_W-1:0] ahb_gate_o,
  output logic [DATA_W-1:0] apb0_gate_o,
  output logic [DATA_W-1:0] apb1_gate_o
);

  logic [NUM_DOMS-1:0]             dom_open;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  for (genvar d = 0; d < NUM_DOMS; d++) begin : g_lock
    logic lk_wr;
    assign lk_wr = bus_wr_en && (bus_addr == ADDR_W'(lock_offset(d)));
    scfg_lock #(.DATA_W(DATA_W), .KEY(UNLOCK_KEY)) u_lock (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (lk_wr),
      .wdata (bus_wdata),
      .open_o(dom_open[d])
    );
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic hit;
    assign hit = bus_wr_en && (bus_addr == ADDR_W'(reg_offset(r)));
    scfg_reg #(.DATA_W(DATA_W), .RESET(DATA_W'(reg_reset(r)))) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (hit),
      .unlocked(dom_open[reg_domain(r)]),
      .wdata   (bus_wdata),
      .q       (regs_q[r])
    );
  end

  scfg_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdmux (
    .addr    (bus_addr),
    .regs_q  (regs_q),
    .dom_open(dom_open),
    .rdata   (bus_rdata)
  );

  assign sys_ctrl_o  = regs_q[0];
  assign core_gate_o = regs_q[1];
  assign ahb_gate_o  = regs_q[2];
  assign apb0_gate_o = regs_q[3];
  assign apb1_gate_o = regs_q[4];

  // R7
  lock_read_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(lock_offset(DOM_SYS)) || bus_addr == ADDR_W'(lock_offset(DOM_CLK)))
      |-> (bus_rdata[DATA_W-1:1] == '0));

  // R5
  sys_domain_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && !dom_open[DOM_CLK]) |=> ($stable(core_gate_o) && $stable(apb1_gate_o)));

endmodule

// File: tb/keyed_cfg_guard_bench.sv
module keyed_cfg_guard_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, sys_o, core_o, ahb_o, apb0_o, apb1_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [31:0] KEY = 32'h51AC_0FFE;

  always #2 clk = ~clk;

  keyed_cfg_guard u_keyed_cfg_guard (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr_en(wr),
    .bus_wdata(wdata), .bus_rdata(rdata), .sys_ctrl_o(sys_o),
    .core_gate_o(core_o), .ahb_gate_o(ahb_o), .apb0_gate_o(apb0_o),
    .apb1_gate_o(apb1_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; wr = 1'b0;
    #1 d = rdata;
  endtask

  task automatic expect_read(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    expect_read("R1 sys lock", 12'h050, 32'h0);
    expect_read("R1 clk lock", 12'h058, 32'h0);
    expect_read("R1 sys_ctrl", 12'h000, 32'h0000_0401);
    expect_read("R1 core",     12'h010, 32'h0000_0FFC);
    expect_read("R1 ahb",      12'h014, 32'h0000_007F);
    expect_read("R1 apb0",     12'h018, 32'h0000_7FFF);
    expect_read("R1 apb1",     12'h01C, 32'h0000_01FF);
    chk("R1 sys_o", sys_o, 32'h0000_0401);
    chk("R1 apb0_o", apb0_o, 32'h0000_7FFF);
  endtask

  task automatic t_locked_drop;
    bus_write(12'h000, 32'hDEAD_0001);
    bus_write(12'h010, 32'hDEAD_0002);
    bus_write(12'h01C, 32'hDEAD_0003);
    expect_read("R4 sys_ctrl dropped", 12'h000, 32'h0000_0401);
    expect_read("R4 core dropped",     12'h010, 32'h0000_0FFC);
    chk("R4 apb1_o unchanged", apb1_o, 32'h0000_01FF);
  endtask

  task automatic t_sys_unlock;
    bus_write(12'h050, KEY);
    expect_read("R2 sys lock reads 1", 12'h050, 32'h1);
    expect_read("R5 clk lock still 0", 12'h058, 32'h0);
    bus_write(12'h000, 32'h0000_0123);
    chk("R5 sys_ctrl written", sys_o, 32'h0000_0123);
    bus_write(12'h010, 32'h0000_0001);
    expect_read("R5 core still blocked", 12'h010, 32'h0000_0FFC);
  endtask

  task automatic t_sys_relock;
    bus_write(12'h050, 32'h51AC_0FFF);
    expect_read("R3 sys lock reads 0", 12'h050, 32'h0);
    bus_write(12'h000, 32'h0000_0777);
    chk("R3 sys_ctrl blocked after relock", sys_o, 32'h0000_0123);
  endtask

  task automatic t_clk_unlock;
    bus_write(12'h058, KEY);
    expect_read("R2 clk lock reads 1", 12'h058, 32'h1);
    expect_read("R6 sys lock still 0", 12'h050, 32'h0);
    bus_write(12'h010, 32'h0000_0AAA);
    bus_write(12'h014, 32'h0000_0055);
    bus_write(12'h018, 32'h0000_1234);
    bus_write(12'h01C, 32'h0000_00F0);
    chk("R6 core_o", core_o, 32'h0000_0AAA);
    chk("R6 ahb_o",  ahb_o,  32'h0000_0055);
    chk("R6 apb0_o", apb0_o, 32'h0000_1234);
    expect_read("R6 apb1 readback", 12'h01C, 32'h0000_00F0);
    bus_write(12'h000, 32'h0000_0999);
    chk("R6 sys_ctrl still blocked", sys_o, 32'h0000_0123);
    bus_write(12'h058, 32'h0000_0000);
    expect_read("R3 clk lock reads 0", 12'h058, 32'h0);
    bus_write(12'h014, 32'h0000_0000);
    chk("R3 ahb blocked after relock", ahb_o, 32'h0000_0055);
  endtask

  task automatic t_lock_always;
    bus_write(12'h058, KEY);
    bus_write(12'h058, KEY);
    expect_read("R7 key twice stays open", 12'h058, 32'h1);
    bus_write(12'h058, 32'hFFFF_FFFF);
    expect_read("R7 shut from open", 12'h058, 32'h0);
    bus_write(12'h058, 32'h1234_5678);
    expect_read("R7 non-key on shut stays shut", 12'h058, 32'h0);
  endtask

  task automatic t_reads_unmapped;
    expect_read("R8 read locked core", 12'h010, 32'h0000_0AAA);
    expect_read("R8 unmapped reads 0", 12'h004, 32'h0);
    bus_write(12'h050, KEY);
    bus_write(12'h058, KEY);
    bus_write(12'h004, 32'hFFFF_FFFF);
    bus_write(12'h020, 32'hFFFF_FFFF);
    expect_read("R8 unmapped still 0", 12'h004, 32'h0);
    chk("R8 sys_o untouched",  sys_o,  32'h0000_0123);
    chk("R8 core_o untouched", core_o, 32'h0000_0AAA);
    chk("R8 apb1_o untouched", apb1_o, 32'h0000_00F0);
  endtask

  task automatic t_timing;
    // both domains open here
    @(negedge clk);
    addr = 12'h018; wdata = 32'h0000_BEEF; wr = 1'b1;
    #1 chk("R9 old before edge", apb0_o, 32'h0000_1234);
    @(negedge clk);
    wr = 1'b0;
    chk("R9 new after edge", apb0_o, 32'h0000_BEEF);
    #1 chk("R9 readback after edge", rdata, 32'h0000_BEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_locked_drop();
    t_sys_unlock();
    t_sys_relock();
    t_clk_unlock();
    t_lock_always();
    t_reads_unmapped();
    t_timing();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule